// File: doc/BRIEF.md
# DMA Channel Descriptor Gating and Abort Control

This block holds the per-channel control state of a multi-channel DMA engine. It decides, for each channel, whether the descriptor just loaded from a linked chain may execute or whether the channel must wait. A descriptor marked valid in its own configuration runs at once. A descriptor not marked valid runs only once software has granted it with a set-valid write.

A set-valid write is accepted ahead of need. It is then held as a pending grant and used up by the first unmarked descriptor that the chain reaches. This lets software release one pause point before the chain arrives there, so the channel does not stall.

Software drives the block through five write-one-to-set command words: set-valid, set-trigger, enable-set, enable-clear and abort. All five share one data bus, and bit n of the data addresses channel n. The transfer engine reports to the block through two per-channel events: a descriptor-loaded event that carries that descriptor's valid flag, and a transfer-done event. Per-channel run, paused, enable, busy, trigger and pending vectors are brought out so that the state can be read back.

Top module: `dma_chan_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, every output vector (run, paused, enable, busy, trigger, pending) is all zero.
- R2: A set-valid write sets the pending flag of every channel whose data bit is 1. A data bit of 0 leaves that channel's flag unchanged. Data bits at positions NUM_CH and above are ignored.
- R3: A descriptor-loaded event with the valid flag 1 sets run and clears paused in the next cycle, and leaves pending unchanged.
- R4: A descriptor-loaded event with the valid flag 0, on a channel whose pending flag is 1, sets run and clears pending in the next cycle.
- R5: A descriptor-loaded event with the valid flag 0, on a channel with no pending flag, sets paused and clears run. A later set-valid write to that channel clears paused and sets run in the next cycle, and no pending flag remains afterwards.
- R6: A set-trigger write sets the trigger bit of every channel whose data bit is 1. A data bit of 0 has no effect.
- R7: An enable-set write sets the enable bits selected by the data, and an enable-clear write clears them. When both strobes select the same channel in the same cycle, the clear wins.
- R8: Busy rises one cycle after trigger and enable are both 1 on a channel. A transfer-done event on that channel clears busy, trigger and run in the next cycle.
- R9: An abort write clears busy, trigger, pending, paused and run of the selected channels in the next cycle. Enabling the channel again afterwards does not make it busy.
- R10: If a set-valid write and a descriptor-loaded event with the valid flag 0 reach the same channel in the same cycle, the grant is consumed at once: run becomes 1 and pending remains 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | REG_W | Shared command write data, bit n selects channel n |
| set_valid_we_i | input | 1 | Strobe for the set-valid command |
| set_trig_we_i | input | 1 | Strobe for the set-trigger command |
| en_set_we_i | input | 1 | Strobe for the enable-set command |
| en_clr_we_i | input | 1 | Strobe for the enable-clear command |
| abort_we_i | input | 1 | Strobe for the abort command |
| desc_load_i | input | NUM_CH | Per-channel event: next descriptor loaded |
| desc_cfg_valid_i | input | NUM_CH | Valid flag of the loaded descriptor |
| xfer_done_i | input | NUM_CH | Per-channel event: transfer finished |
| run_o | output | NUM_CH | Current descriptor may execute |
| paused_o | output | NUM_CH | Channel is waiting for a set-valid grant |
| enable_o | output | NUM_CH | Channel enable state |
| busy_o | output | NUM_CH | Channel is active |
| trig_o | output | NUM_CH | Trigger bit state |
| pending_o | output | NUM_CH | Held set-valid grant |

## Verification
The bench builds the block with NUM_CH = 4 and REG_W = 32. With these values, 28 reserved data bits can be driven high to show they are ignored, and every channel's state can be listed in a single hex digit of the vector table. Four channels are enough to run at the same time a channel that starts at once, one that is released by a pending grant and one that stays paused. The directed tests then cover the abort sequence with a re-enable afterwards, the case where a grant arrives in the same cycle as the descriptor that consumes it, and an enable collision.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef struct packed {
    logic sv;
    logic trig;
    logic en_set;
    logic en_clr;
    logic abort;
  } chan_cmd_t;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chan_pkg::*;
#(
  parameter int NUM_CH = 25,
  parameter int REG_W  = 32
) (
  input  logic [REG_W-1:0] wdata_i,
  input  logic             set_valid_we_i,
  input  logic             set_trig_we_i,
  input  logic             en_set_we_i,
  input  logic             en_clr_we_i,
  input  logic             abort_we_i,
  output chan_cmd_t        cmd_o [NUM_CH]
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign cmd_o[n].sv     = set_valid_we_i & wdata_i[n];
    assign cmd_o[n].trig   = set_trig_we_i  & wdata_i[n];
    assign cmd_o[n].en_set = en_set_we_i    & wdata_i[n];
    assign cmd_o[n].en_clr = en_clr_we_i    & wdata_i[n];
    assign cmd_o[n].abort  = abort_we_i     & wdata_i[n];
  end

  // reserved bits carry no command
  if (REG_W > NUM_CH) begin : g_rsvd
    logic unused_rsvd;
    assign unused_rsvd = ^wdata_i[REG_W-1:NUM_CH];
  end
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dma_chan_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  chan_cmd_t cmd_i,
  input  logic      load_i,
  input  logic      cfg_valid_i,
  input  logic      done_i,
  output logic      run_o,
  output logic      paused_o,
  output logic      en_o,
  output logic      busy_o,
  output logic      trig_o,
  output logic      pend_o
);
  logic run_q, paused_q, en_q, busy_q, trig_q, pend_q;
  logic grant_avail, resume, consume;

  // a grant written in this cycle is usable by a descriptor loaded in this cycle
  assign grant_avail = pend_q | cmd_i.sv;
  assign resume      = paused_q & cmd_i.sv & ~load_i;
  assign consume     = (load_i & ~cfg_valid_i & grant_avail) | resume;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      paused_q <= 1'b0;
      en_q     <= 1'b0;
      busy_q   <= 1'b0;
      trig_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (cmd_i.en_clr)      en_q <= 1'b0;
      else if (cmd_i.en_set) en_q <= 1'b1;

      if (cmd_i.abort) begin
        run_q    <= 1'b0;
        paused_q <= 1'b0;
        busy_q   <= 1'b0;
        trig_q   <= 1'b0;
        pend_q   <= 1'b0;
      end else begin
        if (consume)       pend_q <= 1'b0;
        else if (cmd_i.sv) pend_q <= 1'b1;

        if (load_i) begin
          run_q    <= cfg_valid_i | grant_avail;
          paused_q <= ~cfg_valid_i & ~grant_avail;
        end else if (resume) begin
          run_q    <= 1'b1;
          paused_q <= 1'b0;
        end else if (done_i) begin
          run_q    <= 1'b0;
        end

        if (cmd_i.trig)  trig_q <= 1'b1;
        else if (done_i) trig_q <= 1'b0;

        if (busy_q && done_i)      busy_q <= 1'b0;
        else if (trig_q && en_q)   busy_q <= 1'b1;
      end
    end
  end

  assign run_o    = run_q;
  assign paused_o = paused_q;
  assign en_o     = en_q;
  assign busy_o   = busy_q;
  assign trig_o   = trig_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int NUM_CH = 25,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              set_valid_we_i,
  input  logic              set_trig_we_i,
  input  logic              en_set_we_i,
  input  logic              en_clr_we_i,
  input  logic              abort_we_i,
  input  logic [NUM_CH-1:0] desc_load_i,
  input  logic [NUM_CH-1:0] desc_cfg_valid_i,
  input  logic [NUM_CH-1:0] xfer_done_i,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] paused_o,
  output logic [NUM_CH-1:0] enable_o,
  output logic [NUM_CH-1:0] busy_o,
  output logic [NUM_CH-1:0] trig_o,
  output logic [NUM_CH-1:0] pending_o
);
  chan_cmd_t cmd [NUM_CH];

  dma_cmd_decode #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_dec (
    .wdata_i        (wdata_i),
    .set_valid_we_i (set_valid_we_i),
    .set_trig_we_i  (set_trig_we_i),
    .en_set_we_i    (en_set_we_i),
    .en_clr_we_i    (en_clr_we_i),
    .abort_we_i     (abort_we_i),
    .cmd_o          (cmd)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_slice
    dma_chan_slice u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_i       (cmd[n]),
      .load_i      (desc_load_i[n]),
      .cfg_valid_i (desc_cfg_valid_i[n]),
      .done_i      (xfer_done_i[n]),
      .run_o       (run_o[n]),
      .paused_o    (paused_o[n]),
      .en_o        (enable_o[n]),
      .busy_o      (busy_o[n]),
      .trig_o      (trig_o[n]),
      .pend_o      (pending_o[n])
    );
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int NUM_CH = 25,
  parameter int REG_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_W-1:0]  wdata_i,
  input logic              set_valid_we_i,
  input logic              set_trig_we_i,
  input logic              abort_we_i,
  input logic [NUM_CH-1:0] desc_load_i,
  input logic [NUM_CH-1:0] run_o,
  input logic [NUM_CH-1:0] paused_o,
  input logic [NUM_CH-1:0] enable_o,
  input logic [NUM_CH-1:0] busy_o,
  input logic [NUM_CH-1:0] trig_o,
  input logic [NUM_CH-1:0] pending_o
);
  logic [NUM_CH-1:0] sv_m, trig_m, abort_m;
  assign sv_m    = wdata_i[NUM_CH-1:0] & {NUM_CH{set_valid_we_i}};
  assign trig_m  = wdata_i[NUM_CH-1:0] & {NUM_CH{set_trig_we_i}};
  assign abort_m = wdata_i[NUM_CH-1:0] & {NUM_CH{abort_we_i}};

  // R2
  pend_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pending_o & ~$past(pending_o) & ~$past(sv_m)) == '0));

  // R6
  trig_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((trig_o & ~$past(trig_o) & ~$past(trig_m)) == '0));

  // R5
  paused_run_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o & run_o) == '0);

  // R8
  busy_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((busy_o & ~$past(busy_o) & ~($past(trig_o) & $past(enable_o))) == '0));

  // R9
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_we_i |=> (((busy_o | trig_o | pending_o | paused_o | run_o) & $past(abort_m)) == '0));

  // R5
  resume_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(paused_o) & ~paused_o & ~$past(abort_m | desc_load_i) & ~run_o) == '0));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wdata_i        (wdata_i),
  .set_valid_we_i (set_valid_we_i),
  .set_trig_we_i  (set_trig_we_i),
  .abort_we_i     (abort_we_i),
  .desc_load_i    (desc_load_i),
  .run_o          (run_o),
  .paused_o       (paused_o),
  .enable_o       (enable_o),
  .busy_o         (busy_o),
  .trig_o         (trig_o),
  .pending_o      (pending_o)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
  localparam int NCH = 4;
  localparam int RW  = 32;

  localparam logic [2:0] OP_NONE = 3'd0, OP_SV = 3'd1, OP_TRIG = 3'd2,
                         OP_ENS = 3'd3, OP_ENC = 3'd4, OP_ABT = 3'd5;

  typedef struct packed {
    logic [2:0]     op;
    logic [RW-1:0]  wd;
    logic [NCH-1:0] ld, cfg, dn;
    logic [NCH-1:0] e_pend, e_paus, e_run, e_trig, e_busy, e_en;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{OP_SV,   32'hFFFF_FFF5, 4'h0, 4'h0, 4'h0, 4'h5, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
    '{OP_NONE, 32'h0,         4'h3, 4'h1, 4'h0, 4'h5, 4'h2, 4'h1, 4'h0, 4'h0, 4'h0},
    '{OP_NONE, 32'h0,         4'h4, 4'h0, 4'h0, 4'h1, 4'h2, 4'h5, 4'h0, 4'h0, 4'h0},
    '{OP_SV,   32'h2,         4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h7, 4'h0, 4'h0, 4'h0},
    '{OP_ENS,  32'h3,         4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h7, 4'h0, 4'h0, 4'h3},
    '{OP_TRIG, 32'h9,         4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h7, 4'h9, 4'h0, 4'h3},
    '{OP_NONE, 32'h0,         4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h7, 4'h9, 4'h1, 4'h3},
    '{OP_NONE, 32'h0,         4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 4'h6, 4'h8, 4'h0, 4'h3},
    '{OP_ENC,  32'h1,         4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h6, 4'h8, 4'h0, 4'h2},
    '{OP_ABT,  32'h8,         4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h6, 4'h0, 4'h0, 4'h2},
    '{OP_SV,   32'h0,         4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h6, 4'h0, 4'h0, 4'h2},
    '{OP_ABT,  32'h1,         4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h6, 4'h0, 4'h0, 4'h2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] wdata = '0;
  logic sv_we = 0, trig_we = 0, ens_we = 0, enc_we = 0, abt_we = 0;
  logic [NCH-1:0] ld = '0, cfg = '0, dn = '0;
  logic [NCH-1:0] run, paused, en, busy, trig, pend;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #4ns clk = ~clk;

  dma_chan_ctrl #(.NUM_CH(NCH), .REG_W(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata),
    .set_valid_we_i(sv_we), .set_trig_we_i(trig_we),
    .en_set_we_i(ens_we), .en_clr_we_i(enc_we), .abort_we_i(abt_we),
    .desc_load_i(ld), .desc_cfg_valid_i(cfg), .xfer_done_i(dn),
    .run_o(run), .paused_o(paused), .enable_o(en), .busy_o(busy),
    .trig_o(trig), .pending_o(pend)
  );

  task automatic chk(input string req, input string what,
                     input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wdata = '0; sv_we = 0; trig_we = 0; ens_we = 0; enc_we = 0; abt_we = 0;
    ld = '0; cfg = '0; dn = '0;
  endtask

  // drive at negedge, one posedge, sample at following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "run", run, '0);
    chk("R1", "busy", busy, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "paused", paused, '0);
    chk("R1", "enable", en, '0);
    chk("R1", "trig", trig, '0);
    chk("R1", "pending", pend, '0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      wdata   = TBL[i].wd;
      sv_we   = (TBL[i].op == OP_SV);
      trig_we = (TBL[i].op == OP_TRIG);
      ens_we  = (TBL[i].op == OP_ENS);
      enc_we  = (TBL[i].op == OP_ENC);
      abt_we  = (TBL[i].op == OP_ABT);
      ld = TBL[i].ld; cfg = TBL[i].cfg; dn = TBL[i].dn;
      step();
      chk("R2/R4/R9", $sformatf("pend v%0d", i), pend, TBL[i].e_pend);
      chk("R5", $sformatf("paused v%0d", i), paused, TBL[i].e_paus);
      chk("R3/R4/R5", $sformatf("run v%0d", i), run, TBL[i].e_run);
      chk("R6/R8", $sformatf("trig v%0d", i), trig, TBL[i].e_trig);
      chk("R8", $sformatf("busy v%0d", i), busy, TBL[i].e_busy);
      chk("R7", $sformatf("enable v%0d", i), en, TBL[i].e_en);
    end

    // R9: abort sequence on channel 1, then re-enable must not restart
    wdata = 32'h2; trig_we = 1; step();
    step();
    chk("R9", "busy before abort", busy, 4'h2);
    wdata = 32'h2; enc_we = 1; step();
    chk("R9", "busy after disable", busy, 4'h2);
    wdata = 32'h2; abt_we = 1; step();
    chk("R9", "busy after abort", busy, 4'h0);
    chk("R9", "trig after abort", trig, 4'h0);
    chk("R9", "run after abort", run, 4'h4);
    wdata = 32'h2; ens_we = 1; step();
    step(); step();
    chk("R9", "busy after re-enable", busy, 4'h0);
    chk("R9", "enable after re-enable", en, 4'h2);

    // R10: grant arrives with the descriptor that consumes it (channel 3)
    wdata = 32'h8; sv_we = 1; ld = 4'h8; cfg = 4'h0; step();
    chk("R10", "run", run & 4'h8, 4'h8);
    chk("R10", "pending", pend, 4'h0);
    chk("R10", "paused", paused, 4'h0);

    // R5: pause then resume with no leftover grant (channel 0)
    ld = 4'h1; cfg = 4'h0; step();
    chk("R5", "paused", paused, 4'h1);
    chk("R5", "run", run & 4'h1, 4'h0);
    wdata = 32'h1; sv_we = 1; step();
    chk("R5", "resume paused", paused, 4'h0);
    chk("R5", "resume run", run & 4'h1, 4'h1);
    chk("R5", "resume pending", pend, 4'h0);

    // R7: set and clear collide on channel 2
    wdata = 32'h4; ens_we = 1; enc_we = 1; step();
    chk("R7", "collision", en & 4'h4, 4'h0);

    // R6: zero data has no effect
    wdata = 32'h0; trig_we = 1; step();
    chk("R6", "zero write", trig, 4'h0);

    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule